// File: doc/BRIEF.md
# DMA Descriptor Validity Checker

This block inspects one DMA descriptor of sixteen 32-bit words as the words stream past from the fetch logic. It decides whether the descriptor may be used, and it reports the outcome as a single-cycle result. A failing descriptor raises exactly one bit in an error vector, and the position of that bit encodes both the kind of failure and the channel that fetched the descriptor. In the same result cycle the block presents three more things: a status-register image built from the descriptor's control word, the 48-bit next-descriptor pointer, and the write-back word for the timestamp slot with its done flag set.

The input is a valid/ready word stream. The channel number is sampled along with the first word of each descriptor. A descriptor ends at its sixteenth accepted word, or earlier at any word marked last. The block holds `in_ready` low for exactly the one cycle in which it presents the result, so there is one bubble between descriptors; at every other time it accepts a word on each cycle. The result side is a plain strobe with no back-pressure.

Top module: `dchk_top`

## Requirements
- R1: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. A descriptor ends at its 16th accepted word or at an accepted word with `in_last` high. `in_ready` is low exactly during the result cycle and high otherwise after reset.
- R2: `res_valid` is high for one cycle, in the cycle right after the ending word is accepted. While `res_valid` is low, `res_err` and `wb_valid` are zero.
- R3: When bits 7:0 of word 0 are not 0xA5, the descriptor fails with `res_err` bit 7+channel.
- R4: When control bit 20 is set, the 32-bit wrapping sum of words 0 to 14 must equal word 15; otherwise the descriptor fails with bit 13+channel. When bit 20 is clear, word 15 has no effect on the result.
- R5: When bit 31 of word 5 is set and control bit 10 is clear, the descriptor fails with bit 25+channel. When control bit 10 is set, bit 31 of word 5 has no effect on the result.
- R6: A descriptor that ends before its 16th word fails with bit 1+channel.
- R7: Only the first failing check is reported, in the order short stream, preamble, checksum, done flag. `res_pass` is high in the result cycle exactly when `res_err` is zero.
- R8: `res_status` carries control bits 7:0 at bits 20:13. It also carries control bit 11 at bit 4, bit 18 at 5, bit 20 at 6, bit 19 at 7, bit 21 at 8, bit 10 at 9, word 5 bit 31 at 10, control bit 9 at 11 and control bit 8 at 12. All other status bits are zero.
- R9: `res_next` is formed with bits 15:0 of word 6 in bits 47:32 and word 7 in bits 31:0.
- R10: `wb_valid` is high in the result cycle when the descriptor passes and control bit 9 is set. `wb_word` is word 5 with bit 31 forced to one.
- R11: The channel used for the error position is the `in_chan` value presented with the first word. The value presented with later words has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor word present |
| in_ready | output | 1 | Checker can take a word |
| in_last | input | 1 | Final word of the descriptor |
| in_chan | input | CH_W | Fetching channel, sampled with the first word |
| in_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result strobe |
| res_pass | output | 1 | Descriptor accepted |
| res_err | output | ERR_W | One-hot error code: kind base plus channel |
| res_status | output | 32 | Status-register image |
| res_next | output | 48 | Next-descriptor pointer |
| wb_valid | output | 1 | Write-back word should be stored |
| wb_word | output | 32 | Timestamp word with done flag set |

## Verification
All results appear in the cycle after the rising edge that accepts the ending word, because the capture registers and the end flag update on that same edge. The bench therefore samples `res_valid`, `res_err`, `res_status`, `res_next` and the write-back outputs 1 ns after that edge, and checks there that `in_ready` is low. One edge later it checks that the strobe, the error vector and `wb_valid` have returned to zero. The bench drives every word at a falling edge, and it waits at a falling edge until `in_ready` is high, so the bubble never shifts the count of accepted words.

// File: rtl/dchk_pkg.sv
package dchk_pkg;

  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 16;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int SUM_WORDS  = DESC_WORDS - 1;

  // word slots inside a descriptor
  localparam int CTRL_IDX  = 0;
  localparam int STAMP_IDX = 5;
  localparam int EXT_IDX   = 6;
  localparam int NEXT_IDX  = 7;
  localparam int TAIL_IDX  = DESC_WORDS - 1;

  // control word bit positions
  localparam int CB_IRQ   = 8;
  localparam int CB_WB    = 9;
  localparam int CB_IGN   = 10;
  localparam int CB_BURST = 11;
  localparam int CB_FRAG  = 18;
  localparam int CB_LAST  = 19;
  localparam int CB_SUM   = 20;
  localparam int CB_LFRM  = 21;
  localparam int DONE_BIT = 31;

  localparam logic [7:0] PREAMBLE = 8'hA5;

  // error group bases (bit = base + channel)
  localparam int EB_FETCH = 1;
  localparam int EB_PRE   = 7;
  localparam int EB_SUM   = 13;
  localparam int EB_DONE  = 25;

  // status image positions
  localparam int SB_BURST = 4;
  localparam int SB_FRAG  = 5;
  localparam int SB_SUM   = 6;
  localparam int SB_LAST  = 7;
  localparam int SB_LFRM  = 8;
  localparam int SB_IGN   = 9;
  localparam int SB_DONE  = 10;
  localparam int SB_WB    = 11;
  localparam int SB_IRQ   = 12;
  localparam int SB_PRE   = 13;

  typedef enum logic [2:0] {
    FAIL_NONE,
    FAIL_FETCH,
    FAIL_PRE,
    FAIL_SUM,
    FAIL_DONE
  } fail_kind_e;

  typedef struct packed {
    logic [7:0] pre;
    logic       irq;
    logic       wb;
    logic       ign;
    logic       burst;
    logic       frag;
    logic       last;
    logic       csum;
    logic       lfrm;
  } ctrl_flags_t;

endpackage

// File: rtl/dchk_capture.sv
module dchk_capture
  import dchk_pkg::*;
#(
  parameter int NCHAN = 6,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [WORD_W-1:0] in_data,
  output logic              end_q,
  output logic              short_q,
  output logic [CH_W-1:0]   chan_q,
  output ctrl_flags_t       flags_q,
  output logic [WORD_W-1:0] stamp_q,
  output logic [15:0]       ext_q,
  output logic [WORD_W-1:0] next_q,
  output logic [WORD_W-1:0] sum_q,
  output logic [WORD_W-1:0] tail_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             fire;
  logic             ending;
  logic             first;

  assign in_ready = ~end_q;
  assign fire     = in_valid & in_ready;
  assign first    = (idx_q == IDX_W'(CTRL_IDX));
  assign ending   = fire & (in_last | (idx_q == LAST_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      end_q   <= 1'b0;
      short_q <= 1'b0;
      chan_q  <= '0;
      flags_q <= '0;
      stamp_q <= '0;
      ext_q   <= '0;
      next_q  <= '0;
      sum_q   <= '0;
      tail_q  <= '0;
    end else begin
      end_q <= ending;
      if (fire) begin
        idx_q <= ending ? '0 : idx_q + 1'b1;
        if (ending) short_q <= (idx_q != LAST_IDX);
        if (first) begin
          chan_q        <= in_chan;
          sum_q         <= in_data;
          stamp_q       <= '0;
          ext_q         <= '0;
          next_q        <= '0;
          tail_q        <= '0;
          flags_q.pre   <= in_data[7:0];
          flags_q.irq   <= in_data[CB_IRQ];
          flags_q.wb    <= in_data[CB_WB];
          flags_q.ign   <= in_data[CB_IGN];
          flags_q.burst <= in_data[CB_BURST];
          flags_q.frag  <= in_data[CB_FRAG];
          flags_q.last  <= in_data[CB_LAST];
          flags_q.csum  <= in_data[CB_SUM];
          flags_q.lfrm  <= in_data[CB_LFRM];
        end else begin
          if (idx_q < IDX_W'(SUM_WORDS)) sum_q <= sum_q + in_data;
          if (idx_q == IDX_W'(STAMP_IDX)) stamp_q <= in_data;
          if (idx_q == IDX_W'(EXT_IDX))   ext_q   <= in_data[15:0];
          if (idx_q == IDX_W'(NEXT_IDX))  next_q  <= in_data;
          if (idx_q == IDX_W'(TAIL_IDX))  tail_q  <= in_data;
        end
      end
    end
  end

endmodule

// File: rtl/dchk_judge.sv
module dchk_judge
  import dchk_pkg::*;
#(
  parameter int NCHAN = 6,
  parameter int ERR_W = 32,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              valid,
  input  logic              short_desc,
  input  logic [7:0]        pre,
  input  logic              csum_en,
  input  logic [WORD_W-1:0] sum,
  input  logic [WORD_W-1:0] tail,
  input  logic              done_flag,
  input  logic              ign_done,
  input  logic [CH_W-1:0]   chan,
  output fail_kind_e        kind,
  output logic              pass,
  output logic [ERR_W-1:0]  err
);

  int base;

  always_comb begin
    if (short_desc)                  kind = FAIL_FETCH;
    else if (pre != PREAMBLE)        kind = FAIL_PRE;
    else if (csum_en && sum != tail) kind = FAIL_SUM;
    else if (done_flag && !ign_done) kind = FAIL_DONE;
    else                             kind = FAIL_NONE;
  end

  always_comb begin
    case (kind)
      FAIL_FETCH: base = EB_FETCH;
      FAIL_PRE:   base = EB_PRE;
      FAIL_SUM:   base = EB_SUM;
      FAIL_DONE:  base = EB_DONE;
      default:    base = 0;
    endcase
    if (valid && kind != FAIL_NONE) err = ERR_W'(1) << (base + int'(chan));
    else                            err = '0;
  end

  assign pass = valid && (kind == FAIL_NONE);

endmodule

// File: rtl/dchk_status.sv
module dchk_status
  import dchk_pkg::*;
(
  input  ctrl_flags_t       flags,
  input  logic [WORD_W-1:0] stamp,
  input  logic [15:0]       ext,
  input  logic [WORD_W-1:0] nxt,
  output logic [31:0]       status,
  output logic [47:0]       next_ptr,
  output logic [WORD_W-1:0] wb_word,
  output logic              wb_req
);

  logic [31:0] pre_field;
  logic [31:0] flag_field;

  for (genvar b = 0; b < 32; b++) begin : g_pre
    if (b >= SB_PRE && b < SB_PRE + 8) begin : g_on
      assign pre_field[b] = flags.pre[b - SB_PRE];
    end else begin : g_off
      assign pre_field[b] = 1'b0;
    end
  end

  always_comb begin
    flag_field           = '0;
    flag_field[SB_BURST] = flags.burst;
    flag_field[SB_FRAG]  = flags.frag;
    flag_field[SB_SUM]   = flags.csum;
    flag_field[SB_LAST]  = flags.last;
    flag_field[SB_LFRM]  = flags.lfrm;
    flag_field[SB_IGN]   = flags.ign;
    flag_field[SB_DONE]  = stamp[DONE_BIT];
    flag_field[SB_WB]    = flags.wb;
    flag_field[SB_IRQ]   = flags.irq;
  end

  assign status   = pre_field | flag_field;
  assign next_ptr = {ext, nxt};
  assign wb_word  = stamp | (WORD_W'(1) << DONE_BIT);
  assign wb_req   = flags.wb;

endmodule

// File: rtl/dchk_top.sv
module dchk_top
  import dchk_pkg::*;
#(
  parameter int NCHAN = 6,
  parameter int ERR_W = 32,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [WORD_W-1:0] in_data,
  output logic              res_valid,
  output logic              res_pass,
  output logic [ERR_W-1:0]  res_err,
  output logic [31:0]       res_status,
  output logic [47:0]       res_next,
  output logic              wb_valid,
  output logic [WORD_W-1:0] wb_word
);

  logic              end_q;
  logic              short_q;
  logic [CH_W-1:0]   chan_q;
  ctrl_flags_t       flags_q;
  logic [WORD_W-1:0] stamp_q;
  logic [15:0]       ext_q;
  logic [WORD_W-1:0] next_q;
  logic [WORD_W-1:0] sum_q;
  logic [WORD_W-1:0] tail_q;
  fail_kind_e        kind;
  logic              wb_req;

  dchk_capture #(.NCHAN(NCHAN)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_last  (in_last),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .end_q    (end_q),
    .short_q  (short_q),
    .chan_q   (chan_q),
    .flags_q  (flags_q),
    .stamp_q  (stamp_q),
    .ext_q    (ext_q),
    .next_q   (next_q),
    .sum_q    (sum_q),
    .tail_q   (tail_q)
  );

  dchk_judge #(.NCHAN(NCHAN), .ERR_W(ERR_W)) u_judge (
    .valid      (end_q),
    .short_desc (short_q),
    .pre        (flags_q.pre),
    .csum_en    (flags_q.csum),
    .sum        (sum_q),
    .tail       (tail_q),
    .done_flag  (stamp_q[DONE_BIT]),
    .ign_done   (flags_q.ign),
    .chan       (chan_q),
    .kind       (kind),
    .pass       (res_pass),
    .err        (res_err)
  );

  dchk_status u_status (
    .flags    (flags_q),
    .stamp    (stamp_q),
    .ext      (ext_q),
    .nxt      (next_q),
    .status   (res_status),
    .next_ptr (res_next),
    .wb_word  (wb_word),
    .wb_req   (wb_req)
  );

  assign res_valid = end_q;
  assign wb_valid  = end_q & res_pass & wb_req & (kind == FAIL_NONE);

endmodule

// File: rtl/dchk_sva.sv
module dchk_sva #(
  parameter int NCHAN = 6,
  parameter int ERR_W = 32,
  localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             res_valid,
  input logic             res_pass,
  input logic [ERR_W-1:0] res_err,
  input logic             wb_valid,
  input logic [31:0]      wb_word
);

  assert_last_gives_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> res_valid);

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_quiet_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_err == '0 && !wb_valid));

  assert_bubble_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> in_ready);

  assert_one_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones(res_err) <= 1));

  assert_pass_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_pass == (res_err == '0)));

  assert_wb_only_on_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (res_valid && res_pass && wb_word[31]));

endmodule

bind dchk_top dchk_sva #(.NCHAN(NCHAN), .ERR_W(ERR_W)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .res_valid (res_valid),
  .res_pass  (res_pass),
  .res_err   (res_err),
  .wb_valid  (wb_valid),
  .wb_word   (wb_word)
);

// File: tb/dchk_top_tb.sv
`timescale 1ns/1ps
module dchk_top_tb;

  localparam int NCH  = 6;
  localparam int EW   = 32;
  localparam int CW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_last = 1'b0;
  logic [CW-1:0] in_chan = '0;
  logic [31:0]   in_data = '0;
  logic          res_valid;
  logic          res_pass;
  logic [EW-1:0] res_err;
  logic [31:0]   res_status;
  logic [47:0]   res_next;
  logic          wb_valid;
  logic [31:0]   wb_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] d [16];

  always #5 clk = ~clk;

  dchk_top #(.NCHAN(NCH), .ERR_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_chan(in_chan), .in_data(in_data),
    .res_valid(res_valid), .res_pass(res_pass), .res_err(res_err),
    .res_status(res_status), .res_next(res_next),
    .wb_valid(wb_valid), .wb_word(wb_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // send n words of d[]; last marker on final word unless a full
  // descriptor is sent without it
  task automatic send_desc(input int n, input int ch, input bit mark16);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = d[i];
      in_last  = (i == n - 1) && (n < 16 || mark16);
      in_chan  = CW'((i == 0) ? ch : (ch + 1) % NCH);
      @(posedge clk);
    end
  endtask

  task automatic run_case(input int n, input int ch, input bit mark16);
    logic [31:0] sum;
    logic [31:0] exp_st;
    logic [EW-1:0] exp_err;
    int base;
    bit pass;
    sum = '0;
    for (int i = 0; i < 15; i++) sum = sum + d[i];
    if (n < 16)                            base = 1;
    else if (d[0][7:0] != 8'hA5)           base = 7;
    else if (d[0][20] && sum != d[15])     base = 13;
    else if (d[5][31] && !d[0][10])        base = 25;
    else                                   base = -1;
    pass    = (base < 0);
    exp_err = pass ? '0 : (EW'(1) << (base + ch));
    exp_st  = ({24'd0, d[0][7:0]} << 13) | (32'(d[0][11]) << 4) |
              (32'(d[0][18]) << 5) | (32'(d[0][20]) << 6) |
              (32'(d[0][19]) << 7) | (32'(d[0][21]) << 8) |
              (32'(d[0][10]) << 9) | (32'(d[5][31]) << 10) |
              (32'(d[0][9]) << 11) | (32'(d[0][8]) << 12);

    send_desc(n, ch, mark16);
    #1;
    chk(res_valid == 1'b1, "R2 strobe after ending word", 64'(res_valid), 64'd1);
    chk(in_ready == 1'b0, "R1 ready low in result cycle", 64'(in_ready), 64'd0);
    chk(res_err == exp_err, "R3/R4/R5/R6/R11 error code", 64'(res_err), 64'(exp_err));
    chk(res_pass == pass, "R7 pass flag", 64'(res_pass), 64'(pass));
    chk(wb_valid == (pass && d[0][9]), "R10 write-back request",
        64'(wb_valid), 64'(pass && d[0][9]));
    if (n == 16) begin
      chk(res_status == exp_st, "R8 status image", 64'(res_status), 64'(exp_st));
      chk(res_next == {d[6][15:0], d[7]}, "R9 next pointer", 64'(res_next),
          64'({d[6][15:0], d[7]}));
      if (pass && d[0][9])
        chk(wb_word == (d[5] | 32'h8000_0000), "R10 write-back word",
            64'(wb_word), 64'(d[5] | 32'h8000_0000));
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(posedge clk);
    #1;
    chk(res_valid == 1'b0 && res_err == '0 && wb_valid == 1'b0,
        "R2 outputs quiet after strobe", {res_valid, res_err, wb_valid}, 64'd0);
    chk(in_ready == 1'b1, "R1 ready back after result", 64'(in_ready), 64'd1);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chk(res_valid == 1'b0 && wb_valid == 1'b0 && res_err == '0,
        "R2 reset state", {res_valid, wb_valid, res_err}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);

    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 128; m++) begin
        int n;
        bit csum;
        for (int i = 0; i < 16; i++)
          d[i] = 32'h0101_0101 * (i + 1) + 32'(m * 977) + 32'(ch * 31);
        csum = m[1] ^ m[3] ^ ch[0];
        d[0] = 32'h0000_00A5 | (32'(m[0]) << 8) | (32'(m[1]) << 9) |
               (32'(m[2]) << 10) | (32'(m[3]) << 11) | (32'(m[4]) << 18) |
               (32'(m[5]) << 19) | (32'(m[6]) << 21) | (32'(csum) << 20) |
               (32'h15 << 12) | (32'(m * 3) << 24);
        if (m % 11 == 4) d[0][7:0] = 8'hA4;
        d[5][31] = (m % 3 == 0);
        d[15] = 32'h0;
        for (int i = 0; i < 15; i++) d[15] = d[15] + d[i];
        if (m % 5 == 3) d[15] = d[15] ^ 32'h0000_0100;
        n = (m % 13 == 7) ? (m % 15) + 1 : 16;
        run_case(n, ch, (m % 4) != 1);
      end
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule